// File: doc/BRIEF.md
# Quasi-Cyclic Parity Syndrome Checker

This block receives a hard-decision codeword one bit per clock. As each bit arrives, it updates a 1022-bit syndrome for a quasi-cyclic parity check matrix. The matrix is an array of 2 block rows by 16 block columns. Each block is a 511x511 circulant. Each row of a circulant is the row above it rotated right by one place. Every circulant holds exactly two ones per row. The matrix is never stored. A 64-entry table of first-row offsets describes it, and each arriving `1` bit inverts four syndrome bits whose positions are computed with modular arithmetic.

When the 8176th bit of a word is accepted, the block pulses a completion flag. It also raises a zero-syndrome flag if every syndrome bit is clear. The full syndrome vector is visible at all times so that a downstream stage can use it. A new word can start with an explicit first-bit marker. It can also follow the previous word back to back with no marker.

Top module: `qc_syndrome_check`

## Requirements
- R1: While reset is held, and on the first cycle after it, `synd` is all zero and `word_done` and `synd_zero` are low.
- R2: Codeword column j = 511*c + t (block column c from 0 to 15, t from 0 to 510) maps to syndrome rows r*511 + ((t - p) mod 511), for each block row r in {0,1} and each of the two offsets p of block (r,c).
  - Offset pairs for block row 0, for c = 0..15: 0/176, 12/239, 0/352, 24/431, 0/392, 151/409, 0/351, 9/359, 0/307, 53/329, 0/207, 18/281, 0/399, 202/457, 0/247, 36/261.
  - Offset pairs for block row 1, for c = 0..15: 99/471, 130/473, 198/435, 260/478, 215/420, 282/481, 48/396, 193/445, 273/430, 302/451, 96/379, 191/386, 244/467, 364/470, 51/382, 192/414.
- R3: An accepted bit of value 1 inverts exactly four syndrome bits, two in each block row. An accepted bit of value 0 leaves the syndrome unchanged.
- R4: A cycle with `cw_valid` low and `cw_first` low changes neither the syndrome nor the column position.
- R5: `cw_first` high clears the syndrome and restarts the column at 0. If `cw_valid` is high in the same cycle, that bit is column 0 of the new word. If `cw_valid` is low, the syndrome reads all zero on the next cycle.
- R6: Accepted bits take columns 0, 1, 2 and so on, in order, up to 8175.
- R7: `word_done` is high for exactly one cycle, the cycle after column 8175 is accepted.
- R8: `synd_zero` rises only together with `word_done`. It is then high exactly when the finished word's syndrome is all zero. It holds that value until the next accepted bit or `cw_first`.
- R9: After a word completes, the next accepted bit starts a new word at column 0 with a cleared syndrome, even when `cw_first` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cw_valid | input | 1 | `cw_bit` carries a codeword bit this cycle |
| cw_bit | input | 1 | Hard-decision codeword bit |
| cw_first | input | 1 | Marks the first bit of a word and clears the accumulated state |
| word_done | output | 1 | One-cycle pulse after the final column is accepted |
| synd_zero | output | 1 | The finished word's syndrome is all zero |
| synd | output | 1022 | Running syndrome; bit r*511+i is row i of block row r |

## Verification
The bench builds the block with its default geometry: 511-bit circulants in a 2 by 16 array, with two ones per circulant row. Every stimulus is therefore a full 8176-bit word. This puts in reach the last column of the last block, where the column counter wraps, the word-to-word hand-over without a marker, and the offsets of every block column in both block rows. Single-bit words at columns 0, 523 and 8175 pin the modular row mapping to hand-computed bit positions. A random word with idle gaps, an aborted word and a bare first marker are followed cycle by cycle by a behavioural model.

// File: rtl/qcsc_pkg.sv
// Package: default geometry and the first-row offset table of the
// quasi-cyclic check matrix. The table covers only the default geometry
// (2 block rows, 16 block columns, two ones per circulant row).
package qcsc_pkg;
    localparam int unsigned DEF_CIRC     = 511;
    localparam int unsigned DEF_BLK_ROWS = 2;
    localparam int unsigned DEF_BLK_COLS = 16;
    localparam int unsigned DEF_ROW_WT   = 2;

    // Entry (br*16 + bc)*2 + slot is the position of a one in row 0 of block (br,bc).
    localparam int unsigned OFF_TAB [64] = '{
          0, 176,  12, 239,   0, 352,  24, 431,   0, 392, 151, 409,   0, 351,   9, 359,
          0, 307,  53, 329,   0, 207,  18, 281,   0, 399, 202, 457,   0, 247,  36, 261,
         99, 471, 130, 473, 198, 435, 260, 478, 215, 420, 282, 481,  48, 396, 193, 445,
        273, 430, 302, 451,  96, 379, 191, 386, 244, 467, 364, 470,  51, 382, 192, 414
    };

    // Look up one first-row offset of block (br, bc).
    function automatic int unsigned first_row_off(int unsigned br, int unsigned bc,
                                                  int unsigned slot);
        return OFF_TAB[(br * DEF_BLK_COLS + bc) * DEF_ROW_WT + slot];
    endfunction
endpackage

// File: rtl/qcsc_col_counter.sv
// Column tracker: holds the codeword column of the next bit, split into a block
// column and a position inside the circulant. A restart request forces the
// presented column to 0 in the same cycle. Assumes adv is high only for an
// accepted bit.
module qcsc_col_counter #(
    parameter int unsigned CIRC_N   = 511,
    parameter int unsigned BLK_COLS = 16,
    localparam int unsigned OFF_W   = $clog2(CIRC_N),
    localparam int unsigned BC_W    = $clog2(BLK_COLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             adv,
    output logic [BC_W-1:0]  cur_bc,
    output logic [OFF_W-1:0] cur_t,
    output logic             at_last
);
    logic [BC_W-1:0]  bc_q;
    logic [OFF_W-1:0] t_q;

    // Column seen by this cycle's bit, with restart override.
    assign cur_bc  = restart ? '0 : bc_q;
    assign cur_t   = restart ? '0 : t_q;
    assign at_last = (cur_bc == BC_W'(BLK_COLS - 1)) && (cur_t == OFF_W'(CIRC_N - 1));

    // Step the column on every accepted bit, wrapping after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_q <= '0;
            t_q  <= '0;
        end else if (adv) begin
            if (at_last) begin
                bc_q <= '0;
                t_q  <= '0;
            end else if (cur_t == OFF_W'(CIRC_N - 1)) begin
                bc_q <= cur_bc + 1'b1;
                t_q  <= '0;
            end else begin
                bc_q <= cur_bc;
                t_q  <= cur_t + 1'b1;
            end
        end else if (restart) begin
            bc_q <= '0;
            t_q  <= '0;
        end
    end

    assert_pos_in_circ_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(t_q) < CIRC_N);
endmodule

// File: rtl/qcsc_row_map.sv
// Row mapper: for the presented column, computes which syndrome rows hold a one
// in that matrix column and returns them as a toggle mask. Purely combinational.
// Assumes the offsets of one circulant differ, so each block row gets exactly
// ROW_WT distinct hits.
module qcsc_row_map #(
    parameter int unsigned CIRC_N   = 511,
    parameter int unsigned BLK_ROWS = 2,
    parameter int unsigned BLK_COLS = 16,
    parameter int unsigned ROW_WT   = 2,
    localparam int unsigned OFF_W   = $clog2(CIRC_N),
    localparam int unsigned BC_W    = $clog2(BLK_COLS),
    localparam int unsigned SYN_W   = BLK_ROWS * CIRC_N
) (
    input  logic [BC_W-1:0]  cur_bc,
    input  logic [OFF_W-1:0] cur_t,
    output logic [SYN_W-1:0] toggle_mask
);
    localparam int unsigned RAW_W  = OFF_W + 1;
    localparam int unsigned SIDX_W = $clog2(SYN_W);
    localparam int unsigned HITS   = BLK_ROWS * ROW_WT;

    logic [SIDX_W-1:0] hit_idx [HITS];

    for (genvar br = 0; br < BLK_ROWS; br++) begin : g_brow
        for (genvar s = 0; s < ROW_WT; s++) begin : g_slot
            logic [OFF_W-1:0] p;
            logic [RAW_W-1:0] raw;
            logic [RAW_W-1:0] wrapped;
            // Offset of this slot for the current block column.
            assign p = OFF_W'(qcsc_pkg::first_row_off(br, 32'(cur_bc), s));
            // (t - p) mod CIRC_N without a signed intermediate.
            assign raw     = {1'b0, cur_t} + RAW_W'(CIRC_N) - {1'b0, p};
            assign wrapped = (raw >= RAW_W'(CIRC_N)) ? raw - RAW_W'(CIRC_N) : raw;
            assign hit_idx[br*ROW_WT + s] = SIDX_W'(br * CIRC_N) + SIDX_W'(wrapped);
        end
    end

    // Expand the hit indices into a one-hot-per-hit mask.
    always_comb begin
        toggle_mask = '0;
        for (int i = 0; i < HITS; i++) toggle_mask[hit_idx[i]] = 1'b1;
    end
endmodule

// File: rtl/qcsc_synd_acc.sv
// Syndrome accumulator: a register of SYN_W bits, cleared on a fresh word and
// XORed with the toggle mask for each accepted one bit. Assumes fresh and take
// are already qualified by the caller.
module qcsc_synd_acc #(
    parameter int unsigned SYN_W = 1022,
    parameter int unsigned HITS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fresh,
    input  logic             take,
    input  logic [SYN_W-1:0] toggle_mask,
    output logic [SYN_W-1:0] synd_q
);
    // Clear and/or toggle the running syndrome.
    always_ff @(posedge clk) begin
        if (!rst_n) synd_q <= '0;
        else if (fresh || take)
            synd_q <= (fresh ? '0 : synd_q) ^ (take ? toggle_mask : '0);
    end

    assert_mask_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(toggle_mask) == HITS);
    assert_one_flips_four_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fresh) |=> $countones(synd_q ^ $past(synd_q)) == HITS);
    assert_zero_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !fresh) |=> $stable(synd_q));
    assert_fresh_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && !take) |=> (synd_q == '0));
endmodule

// File: rtl/qc_syndrome_check.sv
// Top: bit-serial syndrome checker for a quasi-cyclic parity check matrix.
// One codeword bit per accepted cycle; word_done pulses after the last column;
// synd_zero reports a zero syndrome for the finished word. Assumes the default
// geometry that the offset table in qcsc_pkg describes.
module qc_syndrome_check #(
    parameter int unsigned CIRC_N   = qcsc_pkg::DEF_CIRC,
    parameter int unsigned BLK_ROWS = qcsc_pkg::DEF_BLK_ROWS,
    parameter int unsigned BLK_COLS = qcsc_pkg::DEF_BLK_COLS,
    parameter int unsigned ROW_WT   = qcsc_pkg::DEF_ROW_WT,
    localparam int unsigned SYN_W   = BLK_ROWS * CIRC_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_valid,
    input  logic             cw_bit,
    input  logic             cw_first,
    output logic             word_done,
    output logic             synd_zero,
    output logic [SYN_W-1:0] synd
);
    localparam int unsigned OFF_W = $clog2(CIRC_N);
    localparam int unsigned BC_W  = $clog2(BLK_COLS);

    logic             complete_q;
    logic             done_q;
    logic             fresh;
    logic             take;
    logic [BC_W-1:0]  cur_bc;
    logic [OFF_W-1:0] cur_t;
    logic             at_last;
    logic [SYN_W-1:0] toggle_mask;

    // A new word starts on a marker or on the first bit after a finished word.
    assign fresh = cw_first | (complete_q & cw_valid);
    assign take  = cw_valid & cw_bit;

    qcsc_col_counter #(.CIRC_N(CIRC_N), .BLK_COLS(BLK_COLS)) u_col (
        .clk(clk), .rst_n(rst_n), .restart(fresh), .adv(cw_valid),
        .cur_bc(cur_bc), .cur_t(cur_t), .at_last(at_last)
    );

    qcsc_row_map #(.CIRC_N(CIRC_N), .BLK_ROWS(BLK_ROWS), .BLK_COLS(BLK_COLS),
                   .ROW_WT(ROW_WT)) u_map (
        .cur_bc(cur_bc), .cur_t(cur_t), .toggle_mask(toggle_mask)
    );

    qcsc_synd_acc #(.SYN_W(SYN_W), .HITS(BLK_ROWS * ROW_WT)) u_acc (
        .clk(clk), .rst_n(rst_n), .fresh(fresh), .take(take),
        .toggle_mask(toggle_mask), .synd_q(synd)
    );

    // Word completion pulse and held completion state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            complete_q <= 1'b0;
        end else begin
            done_q <= cw_valid & at_last;
            if (cw_valid & at_last)       complete_q <= 1'b1;
            else if (cw_first | cw_valid) complete_q <= 1'b0;
        end
    end

    assign word_done = done_q;
    assign synd_zero = complete_q & ~|synd;

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cw_valid && !cw_first) |=> $stable(synd));
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);
    assert_zero_rises_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synd_zero) |-> word_done);
    assert_auto_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && complete_q && !cw_bit) |=> (synd == '0));
endmodule

// File: tb/qc_syndrome_check_tb.sv
module qc_syndrome_check_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CIRC = 511;
    localparam int NCOL = 16;
    localparam int SW   = 2 * CIRC;
    localparam int CWL  = NCOL * CIRC;

    int offs [64] = '{
          0, 176,  12, 239,   0, 352,  24, 431,   0, 392, 151, 409,   0, 351,   9, 359,
          0, 307,  53, 329,   0, 207,  18, 281,   0, 399, 202, 457,   0, 247,  36, 261,
         99, 471, 130, 473, 198, 435, 260, 478, 215, 420, 282, 481,  48, 396, 193, 445,
        273, 430, 302, 451,  96, 379, 191, 386, 244, 467, 364, 470,  51, 382, 192, 414
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v = 1'b0, b = 1'b0, f = 1'b0;
    logic done, ok;
    logic [SW-1:0] syn;

    int n_chk = 0, n_bad = 0;
    bit cmp_on = 0;
    bit finished = 0;
    string cur_req = "R1";
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    qc_syndrome_check dut_i (
        .clk(clk), .rst_n(rst_n), .cw_valid(v), .cw_bit(b), .cw_first(f),
        .word_done(done), .synd_zero(ok), .synd(syn)
    );

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic int row_of(int col, int r, int s);
        int c = col / CIRC;
        int t = col % CIRC;
        int p = offs[(r * NCOL + c) * 2 + s];
        return r * CIRC + ((t - p + CIRC) % CIRC);
    endfunction

    // Behavioural reference model, updated on each rising edge.
    logic [SW-1:0] m_syn;
    int m_pos;
    bit m_complete, m_done;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_syn = '0; m_pos = 0; m_complete = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (f || (m_complete && v)) begin
                m_syn = '0; m_pos = 0; m_complete = 0;
            end
            if (v) begin
                if (b)
                    for (int r = 0; r < 2; r++)
                        for (int s = 0; s < 2; s++)
                            m_syn[row_of(m_pos, r, s)] = ~m_syn[row_of(m_pos, r, s)];
                if (m_pos == CWL - 1) begin
                    m_pos = 0; m_done = 1; m_complete = 1;
                end else m_pos++;
            end
        end
    end

    task automatic check_val(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on && !finished) begin
            n_chk++;
            if (syn !== m_syn) begin
                n_bad++;
                $display("FAIL %s syndrome: actual=%h expected=%h", cur_req, syn, m_syn);
            end
            check_val(cur_req, "word_done vs model", done, m_done);
            check_val(cur_req, "synd_zero vs model", ok, (m_complete && m_syn == '0));
        end
    end

    task automatic idle();
        @(negedge clk); v = 0; b = 0; f = 0;
    endtask

    // Feed one word: mode 0 zeros, 1 single one at flip_col, 2 random.
    task automatic feed_word(int mode, int flip_col, bit use_first, bit gaps);
        for (int j = 0; j < CWL; j++) begin
            logic bb;
            if (gaps) while ((rnd() % 4) == 0) idle();
            bb = (mode == 0) ? 1'b0 : (mode == 1) ? (j == flip_col) : rnd() % 2 == 1;
            @(negedge clk); v = 1; b = bb; f = use_first && (j == 0);
        end
        idle();
    endtask

    task automatic check_four(string req, int i0, int i1, int i2, int i3);
        check_val(req, "ones in syndrome", $countones(syn), 4);
        check_val(req, "bit a", syn[i0], 1);
        check_val(req, "bit b", syn[i1], 1);
        check_val(req, "bit c", syn[i2], 1);
        check_val(req, "bit d", syn[i3], 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_val("R1", "syndrome ones in reset", $countones(syn), 0);
        check_val("R1", "word_done in reset", done, 0);
        check_val("R1", "synd_zero in reset", ok, 0);
        rst_n = 1;
        @(negedge clk);
        check_val("R1", "syndrome ones after reset", $countones(syn), 0);
        check_val("R1", "synd_zero after reset", ok, 0);
        cmp_on = 1;

        // R7 R8: all-zero word
        cur_req = "R8";
        feed_word(0, 0, 1, 0);
        check_val("R7", "done after last column", done, 1);
        check_val("R8", "zero word passes", ok, 1);
        idle();
        check_val("R7", "done one cycle only", done, 0);
        check_val("R8", "pass held", ok, 1);

        // R9 R2: single one at column 0, no marker after a finished word
        cur_req = "R9";
        feed_word(1, 0, 0, 0);
        check_val("R6", "done after 8176 bits", done, 1);
        check_val("R8", "flipped word fails", ok, 0);
        check_four("R9", 0, 335, 923, 551);

        // R2: column 523 (block 1, t 12)
        cur_req = "R2";
        feed_word(1, 523, 1, 0);
        check_four("R2", 0, 284, 904, 561);

        // R2 R6: last column 8175
        feed_word(1, CWL - 1, 1, 0);
        check_four("R6", 474, 249, 829, 607);

        // R4: random word with idle gaps
        cur_req = "R4";
        feed_word(2, 0, 1, 1);
        check_val("R4", "done with gaps", done, 1);
        snap = syn;
        repeat (5) idle();
        n_chk++;
        if (syn !== snap) begin
            n_bad++;
            $display("FAIL R4 idle syndrome: actual=%h expected=%h", syn, snap);
        end
        check_val("R3", "random word ones parity even", $countones(syn) % 2, 0);

        // R5: abort a word with a marker carrying a one at column 0
        cur_req = "R5";
        for (int j = 0; j < 100; j++) begin
            @(negedge clk); v = 1; b = (rnd() % 2 == 1); f = (j == 0);
        end
        feed_word(1, 0, 1, 0);
        check_four("R5", 0, 335, 923, 551);

        // R5: marker without valid clears
        @(negedge clk); v = 0; b = 0; f = 1;
        idle();
        check_val("R5", "bare marker clears", $countones(syn), 0);
        check_val("R5", "pass flag dropped", ok, 0);
        check_val("R7", "no done on marker", done, 0);
        idle();

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule